// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Kick Handshake

This block turns a parent clock into one clock-enable pulse stream per CPU-domain output. Each stream runs at a rate of (32 − N)/32 of the parent clock, where N is a 5-bit ratio value. The block drops pulses evenly across each window of 32 parent cycles, so a downstream register that uses the enable sees a steady reduced rate without needing a second clock.

Software sets the ratios through a small register bus with address, write data, write enable and combinational read data. It writes the new ratio values into a staging register, which only holds them. It then writes a one to a separate kick bit. On the next boundary of the shared 32-cycle window, the block copies the staged values into the active dividers. One cycle later it clears the kick bit, and software polls for that clear to learn that the new rate is in use. While a kick is in progress, the staging register accepts no writes. Reads always show the staged values.

Top module: `frac_en_div`

## Requirements
- R1: After reset, both ratio fields read 0, the kick bit reads 0, and every output asserts its enable on every cycle.
- R2: With a constant ratio field N, every 32 consecutive cycles hold exactly 32 − N enables on that output. Each output depends only on its own field. The ratio register is at address 0x808, with output 0's field at bits [4:0] and output 1's field at bits [12:8] by default.
- R3: Writing 1 to bit 31 of address 0x804 makes that bit read 1. It reads 0 again no more than 33 cycles after the write.
- R4: A new ratio replaces the old one only at a 32-cycle window boundary. The 32 cycles before the switch carry only the old count, and the 32 cycles from the switch onward carry only the new count.
- R5: Writes to the ratio register while the kick bit reads 1 are ignored. The read-back value and the rate that gets applied both stay those staged before the kick.
- R6: Writing 0 to bit 31 of address 0x804 leaves the kick bit at 0 and the output rates unchanged.
- R7: Reads of the ratio register return the staged field values, even when they differ from the ratios in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Register address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| en_out | output | NUM_OUT (2) | Clock-enable pulse per output |

## Verification
A phase accumulator that drifts, or a ratio applied in the middle of a window, shows up at en_out as a wrong pulse count within a single 32-cycle span. The bench keeps a running history of enables so it can count the 32 cycles just before each switch and the 32 cycles just after it. A broken kick path shows up as a kick bit that never clears within 33 cycles, or as a staged value changed by a write during the lockout. The bench sees either one on the first poll or read that follows.

// File: rtl/frac_en_pkg.sv
`timescale 1ns/1ps
package frac_en_pkg;

    localparam int unsigned FIELD_W = 5;
    localparam int unsigned WIN_LEN = 1 << FIELD_W;
    localparam int unsigned MULT_W  = FIELD_W + 1;

    typedef logic [FIELD_W-1:0] ratio_t;
    typedef logic [MULT_W-1:0]  mult_t;

    // per-output divider state: active multiplier and phase accumulator
    typedef struct packed {
        mult_t  mult;
        ratio_t phase;
    } lane_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_RATIO = 2'd1,
        SEL_KICK  = 2'd2
    } sel_e;

    function automatic mult_t ratio_to_mult(ratio_t r);
        return mult_t'(WIN_LEN) - mult_t'(r);
    endfunction

endpackage

// File: rtl/frac_en_regs.sv
`timescale 1ns/1ps
module frac_en_regs
    import frac_en_pkg::*;
#(
    parameter int unsigned            NUM_OUT    = 2,
    parameter int unsigned            ADDR_W     = 12,
    parameter int unsigned            DATA_W     = 32,
    parameter logic [ADDR_W-1:0]      RATIO_ADDR = 'h808,
    parameter logic [ADDR_W-1:0]      KICK_ADDR  = 'h804,
    parameter int unsigned            KICK_BIT   = 31,
    parameter logic [NUM_OUT*8-1:0]   FIELD_LSBS = 16'h0800
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    input  logic                     bus_we,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic                     apply,
    output logic                     kick,
    output ratio_t [NUM_OUT-1:0]     pending
);

    localparam int unsigned LSB_W = $clog2(DATA_W);

    function automatic logic [LSB_W-1:0] lsb_of(int i);
        return FIELD_LSBS[i*8 +: LSB_W];
    endfunction

    sel_e sel;
    logic done_q;

    always_comb begin
        if (bus_addr == RATIO_ADDR)     sel = SEL_RATIO;
        else if (bus_addr == KICK_ADDR) sel = SEL_KICK;
        else                            sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            kick    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            // staging register is locked while an update is in flight
            if (bus_we && sel == SEL_RATIO && !kick) begin
                for (int i = 0; i < NUM_OUT; i++)
                    pending[i] <= bus_wdata[lsb_of(i) +: FIELD_W];
            end
            done_q <= apply;
            if (done_q)
                kick <= 1'b0;
            else if (bus_we && sel == SEL_KICK && bus_wdata[KICK_BIT])
                kick <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RATIO: begin
                for (int i = 0; i < NUM_OUT; i++)
                    bus_rdata[lsb_of(i) +: FIELD_W] = pending[i];
            end
            SEL_KICK:  bus_rdata[KICK_BIT] = kick;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/frac_en_window.sv
`timescale 1ns/1ps
module frac_en_window
    import frac_en_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic boundary
);

    ratio_t cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    // last cycle of the 32-cycle window
    assign boundary = &cnt;

endmodule

// File: rtl/frac_en_accum.sv
`timescale 1ns/1ps
module frac_en_accum
    import frac_en_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   apply,
    input  ratio_t new_ratio,
    output logic   en,
    output mult_t  active_mult
);

    lane_t st;
    mult_t sum;

    assign sum         = mult_t'(st.phase) + st.mult;
    assign en          = sum[MULT_W-1];
    assign active_mult = st.mult;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.mult  <= mult_t'(WIN_LEN);
            st.phase <= '0;
        end else begin
            st.phase <= sum[FIELD_W-1:0];
            if (apply)
                st.mult <= ratio_to_mult(new_ratio);
        end
    end

endmodule

// File: rtl/frac_en_div.sv
`timescale 1ns/1ps
module frac_en_div
    import frac_en_pkg::*;
#(
    parameter int unsigned            NUM_OUT    = 2,
    parameter int unsigned            ADDR_W     = 12,
    parameter int unsigned            DATA_W     = 32,
    parameter logic [ADDR_W-1:0]      RATIO_ADDR = 'h808,
    parameter logic [ADDR_W-1:0]      KICK_ADDR  = 'h804,
    parameter int unsigned            KICK_BIT   = 31,
    parameter logic [NUM_OUT*8-1:0]   FIELD_LSBS = 16'h0800
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_OUT-1:0] en_out
);

    logic                  kick;
    logic                  boundary;
    logic                  apply;
    ratio_t [NUM_OUT-1:0]  pending;
    mult_t  [NUM_OUT-1:0]  active_mult;

    assign apply = kick & boundary;

    frac_en_regs #(
        .NUM_OUT    (NUM_OUT),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .RATIO_ADDR (RATIO_ADDR),
        .KICK_ADDR  (KICK_ADDR),
        .KICK_BIT   (KICK_BIT),
        .FIELD_LSBS (FIELD_LSBS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .apply     (apply),
        .kick      (kick),
        .pending   (pending)
    );

    frac_en_window u_win (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        frac_en_accum u_acc (
            .clk         (clk),
            .rst         (rst),
            .apply       (apply),
            .new_ratio   (pending[g]),
            .en          (en_out[g]),
            .active_mult (active_mult[g])
        );
    end

endmodule

// File: rtl/frac_en_chk.sv
`timescale 1ns/1ps
module frac_en_chk
    import frac_en_pkg::*;
#(
    parameter int unsigned        NUM_OUT   = 2,
    parameter int unsigned        ADDR_W    = 12,
    parameter int unsigned        DATA_W    = 32,
    parameter logic [ADDR_W-1:0]  KICK_ADDR = 'h804,
    parameter int unsigned        KICK_BIT  = 31
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_we,
    input  logic                  kick,
    input  logic                  boundary,
    input  ratio_t [NUM_OUT-1:0]  pending,
    input  mult_t  [NUM_OUT-1:0]  active_mult,
    input  logic [NUM_OUT-1:0]    en_out
);

    localparam int unsigned KICK_LIMIT = WIN_LEN + 1;

    logic [7:0] kick_age;

    always_ff @(posedge clk) begin
        if (rst || !kick) kick_age <= '0;
        else              kick_age <= kick_age + 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!kick && pending == '0));

    p_kick_bound_r3: assert property (@(posedge clk) disable iff (rst)
        kick_age <= 8'(KICK_LIMIT));

    p_kick_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(kick) |-> $past(bus_we && bus_addr == KICK_ADDR && bus_wdata[KICK_BIT]));

    p_switch_at_edge_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_mult) |-> $past(boundary));

    p_stage_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        kick |=> $stable(pending));

    p_zero_kick_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == KICK_ADDR && !bus_wdata[KICK_BIT] && !kick) |=> !kick);

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_rate
        p_full_rate_r2: assert property (@(posedge clk) disable iff (rst)
            (active_mult[g] == mult_t'(WIN_LEN)) |-> en_out[g]);
    end

endmodule

bind frac_en_div frac_en_chk #(
    .NUM_OUT   (NUM_OUT),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .KICK_ADDR (KICK_ADDR),
    .KICK_BIT  (KICK_BIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .kick        (kick),
    .boundary    (boundary),
    .pending     (pending),
    .active_mult (active_mult),
    .en_out      (en_out)
);

// File: tb/tb_frac_en_div.sv
`timescale 1ns/1ps
module tb_frac_en_div;

    localparam logic [11:0] A_RATIO = 12'h808;
    localparam logic [11:0] A_KICK  = 12'h804;
    localparam int          KB      = 31;

    // each entry: {field for output 1, field for output 0}
    localparam logic [9:0] VEC [8] = '{
        {5'd31, 5'd0},  {5'd0, 5'd31}, {5'd30, 5'd1},  {5'd15, 5'd16},
        {5'd7,  5'd7},  {5'd31, 5'd31}, {5'd0, 5'd0},  {5'd3,  5'd24}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic [1:0]  en_out;

    logic [63:0] hist0 = '0;
    logic [63:0] hist1 = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int old0     = 32;
    int old1     = 32;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    frac_en_div dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .en_out    (en_out)
    );

    always @(negedge clk) begin
        hist0 <= {hist0[62:0], en_out[0]};
        hist1 <= {hist1[62:0], en_out[1]};
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int f0, input int f1);
        return (32'(f1 & 31) << 8) | 32'(f0 & 31);
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic poll_and_check(input int n0, input int n1);
        int n = 0;
        bus_addr = A_KICK;
        #1;
        while (bus_rdata[KB] && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
        check(n >= 1 && n <= 33, "R3 kick self-clear", n, 33);
        check($countones(hist0[33:2]) == old0, "R4 old window out0", $countones(hist0[33:2]), old0);
        check($countones(hist1[33:2]) == old1, "R4 old window out1", $countones(hist1[33:2]), old1);
        repeat (30) @(negedge clk);
        #1;
        check($countones(hist0[31:0]) == n0, "R2 new rate out0", $countones(hist0[31:0]), n0);
        check($countones(hist1[31:0]) == n1, "R2 new rate out1", $countones(hist1[31:0]), n1);
        old0 = n0;
        old1 = n1;
    endtask

    task automatic apply_check(input int f0, input int f1);
        bus_write(A_RATIO, mk(f0, f1));
        bus_write(A_KICK, 32'h8000_0000);
        poll_and_check(32 - f0, 32 - f1);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(A_RATIO, rd);
        check(rd == 32'h0, "R1 ratio after reset", int'(rd), 0);
        bus_read(A_KICK, rd);
        check(rd == 32'h0, "R1 kick after reset", int'(rd), 0);
        check(en_out == 2'b11, "R1 enables after reset", int'(en_out), 3);
        repeat (40) @(negedge clk);
        #1;
        check($countones(hist0[31:0]) == 32, "R1 full rate out0", $countones(hist0[31:0]), 32);
        check($countones(hist1[31:0]) == 32, "R1 full rate out1", $countones(hist1[31:0]), 32);

        // R7 staged read-back, R6 zero kick has no effect
        bus_write(A_RATIO, mk(5, 9));
        bus_read(A_RATIO, rd);
        check(rd == mk(5, 9), "R7 staged readback", int'(rd), int'(mk(5, 9)));
        bus_write(A_KICK, 32'h0);
        bus_read(A_KICK, rd);
        check(rd[KB] == 1'b0, "R6 zero write keeps kick clear", int'(rd[KB]), 0);
        repeat (40) @(negedge clk);
        #1;
        check($countones(hist0[31:0]) == old0, "R6 rate unchanged out0", $countones(hist0[31:0]), old0);
        check($countones(hist1[31:0]) == old1, "R7 active differs from staged out1", $countones(hist1[31:0]), old1);
        apply_check(5, 9);

        // R5: writes during a kick are dropped
        bus_write(A_RATIO, mk(20, 2));
        bus_write(A_KICK, 32'h8000_0000);
        bus_write(A_RATIO, mk(3, 3));
        bus_read(A_RATIO, rd);
        check(rd == mk(20, 2), "R5 staged value locked", int'(rd), int'(mk(20, 2)));
        poll_and_check(12, 30);

        // table of ratio pairs
        for (int i = 0; i < 8; i++)
            apply_check(int'(VEC[i][4:0]), int'(VEC[i][9:5]));

        // sweep every field value on both outputs
        for (int v = 0; v < 32; v++)
            apply_check(v, (v * 7) % 32);

        finished = 1'b1;
        report();
    end

endmodule